// File: doc/BRIEF.md
# Departure Time-Stamp Allocator

This block decides, for every flit that reaches a shared-buffer router stage in a given cycle, the future cycle in which that flit will leave through its out-port. It keeps a cyclic timeline of `SLOTS` departure slots. For each slot it holds a usage count per out-port. Every out-port has its own link-width limit, which is the most flits it can send in one slot. Requests arriving together are served one after another in a fixed order. Each valid request receives either a stamp, naming the earliest slot that still has room for its port, or a retry.

Two request groups feed the block. Fresh arrivals come from the input side. Re-entry requests carry flits that a later buffer-assignment step turned away, and they are served ahead of fresh arrivals. The timeline moves forward by one slot every clock. The slot that is departing now is reported on `now_slot` together with its per-port load, and its counters are emptied as the window moves on. That slot then becomes the far end of the window. A stamp is an absolute slot index. The flit leaves in the cycle in which `now_slot` equals that stamp.

Top module: `tsa_alloc`

## Requirements
- R1: After reset, `now_slot` is 0, every `now_load` entry is 0, and no grant or retry is raised while no request is valid.
- R2: A granted stamp is never the slot departing in the same cycle. It is the first slot, counting forward from `now_slot + 1`, whose usage for the requested port is still below that port's limit.
- R3: For an out-port p, the number of flits stamped into any one slot never exceeds `PORT_CAP[p]`, so `now_load[p]` never exceeds it either.
- R4: Requests in one cycle are served in this order: re-entry index 0 upward, then fresh index 0 upward. An earlier requestor's grant is visible to every later requestor in the same cycle.
- R5: Each valid request raises exactly one of grant or retry in the same cycle. Retry is raised when no slot at offsets 1 to `SLOTS-1` has room for the port. An invalid request raises neither.
- R6: `now_slot` advances by one every clock and wraps from `SLOTS-1` to 0.
- R7: `now_load[p]` equals the number of grants given earlier for port p into the slot now departing. After it departs, that slot's counts are zero and it can be granted again at offset `SLOTS-1`.
- R8: Limits are set per port (default: port 0 allows 3, port 1 allows 2, ports 2 and 3 allow 1), and each port is filled up to its own limit before its next slot is used.
- R9: Stamps are computed modulo `SLOTS`, so a grant at an offset past the top index wraps to a low slot index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| re_vld | input | N_RE | Re-entry request valid, one bit per re-entry requestor |
| re_port | input | N_RE x PORT_W | Out-port of each re-entry request |
| in_vld | input | N_IN | Fresh request valid, one bit per input |
| in_port | input | N_IN x PORT_W | Out-port of each fresh request |
| re_gnt | output | N_RE | Re-entry request stamped this cycle |
| re_retry | output | N_RE | Re-entry request found no room |
| re_stamp | output | N_RE x SLOT_W | Departure slot given to each re-entry request |
| in_gnt | output | N_IN | Fresh request stamped this cycle |
| in_retry | output | N_IN | Fresh request found no room |
| in_stamp | output | N_IN x SLOT_W | Departure slot given to each fresh request |
| now_slot | output | SLOT_W | Index of the slot departing this cycle |
| now_load | output | N_PORT x CNT_W | Flits departing this cycle on each out-port |

## Verification
Two functions can act on the same port in the same cycle. One is serving re-entry requests ahead of fresh arrivals. The other is reopening the freshly cleared far-end slot as the window advances. The bench provokes both by flooding a port whose limit is 1 for two consecutive cycles. In the second cycle only offsets `SLOTS-2` and `SLOTS-1` are free, so both re-entry requests must take those slots, one with a wrapped index, while every fresh request must retry. A behavioural reference model run on every clock judges long random mixes of both request groups, and its stamps, retries and departing loads must match the design exactly.

// File: rtl/tsa_pkg.sv
// Package tsa_pkg
// Default sizing shared by the allocator modules and its checker.
// Assumes: SLOTS is a power of two and at least 2.
package tsa_pkg;
    parameter int unsigned TSA_N_IN   = 4;
    parameter int unsigned TSA_N_RE   = 2;
    parameter int unsigned TSA_N_PORT = 4;
    parameter int unsigned TSA_SLOTS  = 8;
    parameter int unsigned TSA_CNT_W  = 3;
endpackage

// File: rtl/tsa_first_free.sv
// Module tsa_first_free
// Finds the lowest set bit of a free-slot mask and returns its index.
// Assumes: W >= 2. When no bit is set, any_free is low and idx is 0.
module tsa_first_free #(
    parameter int unsigned W     = 8,
    parameter int unsigned IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     free,
    output logic             any_free,
    output logic [IDX_W-1:0] idx
);
    // Priority scan: high to low, so that the lowest free index wins.
    always_comb begin
        any_free = 1'b0;
        idx      = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (free[i]) begin
                any_free = 1'b1;
                idx      = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tsa_stage.sv
// Module tsa_stage
// One requestor's step in the same-cycle grant chain. It sees the usage
// after all higher-priority requestors, picks the earliest slot offset
// (never 0, the slot departing now) with room for its port, and passes on
// the usage with its own grant added.
// Assumes: use_in is indexed by offset from the departing slot.
module tsa_stage #(
    parameter int unsigned N_PORT = 4,
    parameter int unsigned SLOTS  = 8,
    parameter int unsigned CNT_W  = 3,
    parameter logic [N_PORT-1:0][CNT_W-1:0] PORT_CAP = '0,
    localparam int unsigned PORT_W = $clog2(N_PORT),
    localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
    input  logic                                     vld,
    input  logic [PORT_W-1:0]                        port,
    input  logic [SLOTS-1:0][N_PORT-1:0][CNT_W-1:0]  use_in,
    output logic                                     found,
    output logic [SLOT_W-1:0]                        off,
    output logic [SLOTS-1:0][N_PORT-1:0][CNT_W-1:0]  use_out
);
    logic [SLOTS-1:0] room;
    logic             any_room;

    // Room mask: offsets 1..SLOTS-1 whose count for this port is below its limit.
    always_comb begin
        room = '0;
        for (int d = 1; d < SLOTS; d++) begin
            room[d] = (use_in[d][port] < PORT_CAP[port]);
        end
    end

    tsa_first_free #(.W(SLOTS), .IDX_W(SLOT_W)) u_find (
        .free     (room),
        .any_free (any_room),
        .idx      (off)
    );

    assign found = vld & any_room;

    // Usage forward: add this requestor's grant for the next stage.
    always_comb begin
        use_out = use_in;
        if (found) begin
            use_out[off][port] = use_in[off][port] + CNT_W'(1);
        end
    end
endmodule

// File: rtl/tsa_usage_table.sv
// Module tsa_usage_table
// Holds the cyclic per-slot, per-port usage counters and the departing-slot
// pointer. It presents the counters rotated so that index 0 is the slot
// departing now. It takes back the updated rotated view each clock, empties
// the departing slot and advances the pointer by one.
// Assumes: SLOTS is a power of two; synchronous active-low reset.
module tsa_usage_table #(
    parameter int unsigned N_PORT = 4,
    parameter int unsigned SLOTS  = 8,
    parameter int unsigned CNT_W  = 3,
    localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic [SLOTS-1:0][N_PORT-1:0][CNT_W-1:0]  nxt_rel,
    output logic [SLOTS-1:0][N_PORT-1:0][CNT_W-1:0]  cur_rel,
    output logic [SLOT_W-1:0]                        head
);
    logic [SLOTS-1:0][N_PORT-1:0][CNT_W-1:0] cnt;
    logic [SLOTS-1:0][N_PORT-1:0][CNT_W-1:0] back_abs;

    // Rotate absolute storage into the offset-from-head view.
    always_comb begin
        for (int d = 0; d < SLOTS; d++) begin
            cur_rel[d] = cnt[SLOT_W'(head + SLOT_W'(d))];
        end
    end

    // Rotate the updated offset view back into absolute slot order.
    always_comb begin
        for (int s = 0; s < SLOTS; s++) begin
            back_abs[s] = nxt_rel[SLOT_W'(SLOT_W'(s) - head)];
        end
    end

    // Counter storage: write back grants and empty the departing slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            for (int s = 0; s < SLOTS; s++) begin
                if (SLOT_W'(s) == head) begin
                    cnt[s] <= '0;
                end else begin
                    cnt[s] <= back_abs[s];
                end
            end
        end
    end

    // Departing-slot pointer: one step per clock, wrapping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
        end else begin
            head <= head + SLOT_W'(1);
        end
    end
endmodule

// File: rtl/tsa_alloc.sv
// Module tsa_alloc
// Departure time-stamp allocator. Re-entry and fresh requests are ranked
// into one priority list (re-entry first, low index first) and passed
// through a chain of tsa_stage steps. Each step grants the earliest slot
// that keeps its port within its per-slot link-width limit. Otherwise the
// request gets a retry. Answers are combinational in the request cycle, and
// the grants are committed to the usage table at the next clock.
// Assumes: SLOTS is a power of two, N_PORT is a power of two, and every
// PORT_CAP entry is at least 1 and fits in CNT_W bits.
module tsa_alloc
    import tsa_pkg::*;
#(
    parameter int unsigned N_IN   = TSA_N_IN,
    parameter int unsigned N_RE   = TSA_N_RE,
    parameter int unsigned N_PORT = TSA_N_PORT,
    parameter int unsigned SLOTS  = TSA_SLOTS,
    parameter int unsigned CNT_W  = TSA_CNT_W,
    parameter logic [N_PORT-1:0][CNT_W-1:0] PORT_CAP = {3'd1, 3'd1, 3'd2, 3'd3},
    localparam int unsigned PORT_W = $clog2(N_PORT),
    localparam int unsigned SLOT_W = $clog2(SLOTS),
    localparam int unsigned N_TOT  = N_RE + N_IN
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_RE-1:0]               re_vld,
    input  logic [N_RE-1:0][PORT_W-1:0]   re_port,
    input  logic [N_IN-1:0]               in_vld,
    input  logic [N_IN-1:0][PORT_W-1:0]   in_port,
    output logic [N_RE-1:0]               re_gnt,
    output logic [N_RE-1:0]               re_retry,
    output logic [N_RE-1:0][SLOT_W-1:0]   re_stamp,
    output logic [N_IN-1:0]               in_gnt,
    output logic [N_IN-1:0]               in_retry,
    output logic [N_IN-1:0][SLOT_W-1:0]   in_stamp,
    output logic [SLOT_W-1:0]             now_slot,
    output logic [N_PORT-1:0][CNT_W-1:0]  now_load
);
    typedef logic [SLOTS-1:0][N_PORT-1:0][CNT_W-1:0] usage_t;

    logic [N_TOT-1:0]              rq_vld;
    logic [N_TOT-1:0][PORT_W-1:0]  rq_port;
    logic [N_TOT-1:0]              rq_found;
    logic [N_TOT-1:0][SLOT_W-1:0]  rq_off;
    logic [N_TOT-1:0][SLOT_W-1:0]  rq_stamp;
    usage_t                        chain [N_TOT+1];
    usage_t                        cur_rel;

    tsa_usage_table #(.N_PORT(N_PORT), .SLOTS(SLOTS), .CNT_W(CNT_W)) u_tab (
        .clk     (clk),
        .rst_n   (rst_n),
        .nxt_rel (chain[N_TOT]),
        .cur_rel (cur_rel),
        .head    (now_slot)
    );

    assign chain[0] = cur_rel;
    assign now_load = cur_rel[0];

    // Rank requestors: re-entry first, then fresh arrivals.
    for (genvar k = 0; k < N_TOT; k++) begin : g_rank
        if (k < N_RE) begin : g_re
            assign rq_vld[k]  = re_vld[k];
            assign rq_port[k] = re_port[k];
        end else begin : g_in
            assign rq_vld[k]  = in_vld[k-N_RE];
            assign rq_port[k] = in_port[k-N_RE];
        end
    end

    // Grant chain: one stage per requestor in priority order.
    for (genvar k = 0; k < N_TOT; k++) begin : g_chain
        tsa_stage #(
            .N_PORT   (N_PORT),
            .SLOTS    (SLOTS),
            .CNT_W    (CNT_W),
            .PORT_CAP (PORT_CAP)
        ) u_st (
            .vld     (rq_vld[k]),
            .port    (rq_port[k]),
            .use_in  (chain[k]),
            .found   (rq_found[k]),
            .off     (rq_off[k]),
            .use_out (chain[k+1])
        );
        assign rq_stamp[k] = now_slot + rq_off[k];
    end

    // Answer mapping back to the two request groups.
    for (genvar k = 0; k < N_TOT; k++) begin : g_ans
        if (k < N_RE) begin : g_re
            assign re_gnt[k]   = rq_found[k];
            assign re_retry[k] = rq_vld[k] & ~rq_found[k];
            assign re_stamp[k] = rq_stamp[k];
        end else begin : g_in
            assign in_gnt[k-N_RE]   = rq_found[k];
            assign in_retry[k-N_RE] = rq_vld[k] & ~rq_found[k];
            assign in_stamp[k-N_RE] = rq_stamp[k];
        end
    end
endmodule

// File: rtl/tsa_alloc_chk.sv
// Module tsa_alloc_chk
// Property checker for tsa_alloc, attached with the bind below.
// Assumes: the same parameters as the allocator it observes.
module tsa_alloc_chk #(
    parameter int unsigned N_IN   = 4,
    parameter int unsigned N_RE   = 2,
    parameter int unsigned N_PORT = 4,
    parameter int unsigned SLOTS  = 8,
    parameter int unsigned CNT_W  = 3,
    parameter logic [N_PORT-1:0][CNT_W-1:0] PORT_CAP = '0,
    localparam int unsigned PORT_W = $clog2(N_PORT),
    localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [N_RE-1:0]               re_vld,
    input logic [N_RE-1:0][PORT_W-1:0]   re_port,
    input logic [N_IN-1:0]               in_vld,
    input logic [N_IN-1:0][PORT_W-1:0]   in_port,
    input logic [N_RE-1:0]               re_gnt,
    input logic [N_RE-1:0]               re_retry,
    input logic [N_RE-1:0][SLOT_W-1:0]   re_stamp,
    input logic [N_IN-1:0]               in_gnt,
    input logic [N_IN-1:0]               in_retry,
    input logic [N_IN-1:0][SLOT_W-1:0]   in_stamp,
    input logic [SLOT_W-1:0]             now_slot,
    input logic [N_PORT-1:0][CNT_W-1:0]  now_load
);
    logic                         armed;
    logic [N_PORT-1:0][CNT_W-1:0] n_next;

    // Arm the step check once one clock has passed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // Per-port count of grants aimed at the slot that departs next.
    always_comb begin
        n_next = '0;
        for (int j = 0; j < N_RE; j++) begin
            if (re_gnt[j] && re_stamp[j] == now_slot + SLOT_W'(1))
                n_next[re_port[j]] = n_next[re_port[j]] + CNT_W'(1);
        end
        for (int i = 0; i < N_IN; i++) begin
            if (in_gnt[i] && in_stamp[i] == now_slot + SLOT_W'(1))
                n_next[in_port[i]] = n_next[in_port[i]] + CNT_W'(1);
        end
    end

    // R6
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> now_slot == SLOT_W'($past(now_slot) + SLOT_W'(1)));

    for (genvar p = 0; p < N_PORT; p++) begin : g_port
        // R3
        load_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            now_load[p] <= PORT_CAP[p]);
        // R7
        load_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (n_next[p] != '0) |=> now_load[p] >= $past(n_next[p]));
    end

    for (genvar j = 0; j < N_RE; j++) begin : g_re
        // R5
        re_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
            re_vld[j] |-> (re_gnt[j] != re_retry[j]));
        // R5
        re_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !re_vld[j] |-> !(re_gnt[j] || re_retry[j]));
        // R2
        re_not_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
            re_gnt[j] |-> re_stamp[j] != now_slot);
        for (genvar i = 0; i < N_IN; i++) begin : g_vs_in
            // R4
            re_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (re_retry[j] && in_gnt[i]) |-> in_port[i] != re_port[j]);
        end
    end

    for (genvar i = 0; i < N_IN; i++) begin : g_in
        // R5
        in_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_vld[i] |-> (in_gnt[i] != in_retry[i]));
        // R2
        in_not_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_gnt[i] |-> in_stamp[i] != now_slot);
    end
endmodule

bind tsa_alloc tsa_alloc_chk #(
    .N_IN     (N_IN),
    .N_RE     (N_RE),
    .N_PORT   (N_PORT),
    .SLOTS    (SLOTS),
    .CNT_W    (CNT_W),
    .PORT_CAP (PORT_CAP)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .re_vld   (re_vld),
    .re_port  (re_port),
    .in_vld   (in_vld),
    .in_port  (in_port),
    .re_gnt   (re_gnt),
    .re_retry (re_retry),
    .re_stamp (re_stamp),
    .in_gnt   (in_gnt),
    .in_retry (in_retry),
    .in_stamp (in_stamp),
    .now_slot (now_slot),
    .now_load (now_load)
);

// File: tb/sim_tsa_alloc.sv
// Bench for tsa_alloc: directed corner cases plus a behavioural reference
// model compared on every clock.
module sim_tsa_alloc;
    localparam int NI = 4;
    localparam int NR = 2;
    localparam int NP = 4;
    localparam int NS = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NR-1:0]       re_vld = '0;
    logic [NR-1:0][1:0]  re_port = '0;
    logic [NI-1:0]       in_vld = '0;
    logic [NI-1:0][1:0]  in_port = '0;
    logic [NR-1:0]       re_gnt, re_retry;
    logic [NR-1:0][2:0]  re_stamp;
    logic [NI-1:0]       in_gnt, in_retry;
    logic [NI-1:0][2:0]  in_stamp;
    logic [2:0]          now_slot;
    logic [NP-1:0][2:0]  now_load;

    int n_chk = 0;
    int n_fail = 0;
    int cap_m [NP] = '{3, 2, 1, 1};
    int use_m [NS][NP];
    int head_m = 0;

    always #5 clk = ~clk;

    tsa_alloc u0 (
        .clk(clk), .rst_n(rst_n),
        .re_vld(re_vld), .re_port(re_port), .in_vld(in_vld), .in_port(in_port),
        .re_gnt(re_gnt), .re_retry(re_retry), .re_stamp(re_stamp),
        .in_gnt(in_gnt), .in_retry(in_retry), .in_stamp(in_stamp),
        .now_slot(now_slot), .now_load(now_load)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference model: serve in priority order, compare, then commit.
    task automatic run_cycle();
        #1;
        check(int'(now_slot) == head_m, "R6", "now_slot", int'(now_slot), head_m);
        for (int p = 0; p < NP; p++)
            check(int'(now_load[p]) == use_m[head_m][p], "R7", "now_load",
                  int'(now_load[p]), use_m[head_m][p]);
        for (int k = 0; k < NR + NI; k++) begin
            bit v, g, r;
            int pt, st, eg, es;
            v  = (k < NR) ? re_vld[k]  : in_vld[k-NR];
            pt = (k < NR) ? int'(re_port[k]) : int'(in_port[k-NR]);
            g  = (k < NR) ? re_gnt[k]   : in_gnt[k-NR];
            r  = (k < NR) ? re_retry[k] : in_retry[k-NR];
            st = (k < NR) ? int'(re_stamp[k]) : int'(in_stamp[k-NR]);
            eg = 0; es = 0;
            if (v) begin
                for (int d = 1; d < NS; d++) begin
                    int s;
                    s = (head_m + d) % NS;
                    if (eg == 0 && use_m[s][pt] < cap_m[pt]) begin
                        eg = 1; es = s; use_m[s][pt]++;
                    end
                end
            end
            check(int'(g) == eg, "R4", "grant", int'(g), eg);
            check(int'(r) == ((v && eg == 0) ? 1 : 0), "R5", "retry", int'(r),
                  (v && eg == 0) ? 1 : 0);
            if (eg == 1) check(st == es, "R2", "stamp", st, es);
        end
        for (int p = 0; p < NP; p++) use_m[head_m][p] = 0;
        head_m = (head_m + 1) % NS;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        re_vld = '0; in_vld = '0;
        for (int c = 0; c < n; c++) run_cycle();
    endtask

    task automatic flood(input int pt);
        re_vld = '1; in_vld = '1;
        for (int j = 0; j < NR; j++) re_port[j] = 2'(pt);
        for (int i = 0; i < NI; i++) in_port[i] = 2'(pt);
    endtask

    function automatic int ahead(input int d);
        return (int'(now_slot) + d) % NS;
    endfunction

    initial begin
        for (int s = 0; s < NS; s++)
            for (int p = 0; p < NP; p++) use_m[s][p] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check(now_slot == 3'd0, "R1", "reset now_slot", int'(now_slot), 0);
        check(now_load == '0, "R1", "reset now_load", int'(now_load), 0);
        check((re_gnt | re_retry | in_gnt | in_retry) == '0, "R1", "idle answers",
              int'(re_gnt | re_retry | in_gnt | in_retry), 0);
        run_cycle();

        // R2 lone request on an empty table takes the next slot
        in_vld = 4'b0100; in_port[2] = 2'd0;
        #1;
        check(in_gnt[2] && int'(in_stamp[2]) == ahead(1), "R2", "lone stamp",
              int'(in_stamp[2]), ahead(1));
        run_cycle();
        idle(NS);

        // R4 six requests to a limit-1 port: stamps follow priority order
        flood(3);
        #1;
        for (int j = 0; j < NR; j++)
            check(int'(re_stamp[j]) == ahead(j + 1), "R4", "re order",
                  int'(re_stamp[j]), ahead(j + 1));
        for (int i = 0; i < NI; i++)
            check(int'(in_stamp[i]) == ahead(NR + i + 1), "R4", "in order",
                  int'(in_stamp[i]), ahead(NR + i + 1));
        run_cycle();

        // R5, R9 second flood: re-entry takes the last two offsets, fresh retries
        #1;
        check(re_gnt == 2'b11 && int'(re_stamp[0]) == ahead(6), "R9", "re0 offset6",
              int'(re_stamp[0]), ahead(6));
        check(int'(re_stamp[1]) == ahead(7), "R9", "re1 wrap", int'(re_stamp[1]), ahead(7));
        check(in_retry == 4'b1111 && in_gnt == '0, "R5", "fresh retry",
              int'(in_retry), 15);
        run_cycle();
        idle(NS);

        // R8 limit-3 port fills one slot before the next
        flood(0);
        #1;
        check(int'(in_stamp[0]) == ahead(1) && int'(in_stamp[1]) == ahead(2), "R8",
              "port0 fill", int'(in_stamp[1]), ahead(2));
        run_cycle();
        idle(0);
        #1;
        // R7 the slot filled above now departs with three flits
        check(int'(now_load[0]) == 3, "R7", "departing load", int'(now_load[0]), 3);
        @(negedge clk);
        head_m = (head_m + 1) % NS;
        for (int p = 0; p < NP; p++) use_m[(head_m + NS - 1) % NS][p] = 0;
        idle(NS);

        // Random mixes, biased toward narrow ports for contention
        for (int c = 0; c < 3000; c++) begin
            for (int j = 0; j < NR; j++) begin
                re_vld[j] = ($urandom_range(0, 9) < 4);
                re_port[j] = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 1))
                                                         : 2'($urandom_range(2, 3));
            end
            for (int i = 0; i < NI; i++) begin
                in_vld[i] = ($urandom_range(0, 9) < 6);
                in_port[i] = 2'($urandom_range(0, 3));
            end
            run_cycle();
        end
        idle(2);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule